// File: doc/BRIEF.md
# Rotated Immediate Encode/Decode Unit

This block translates between full 32-bit constants and a packed 12-bit immediate code. The code holds an 8-bit base byte in its low bits and a 4-bit scale in its high bits. The value it stands for is the zero-extended byte rotated right by twice the scale. Only part of the 32-bit space can be reached this way, and several codes reach the same value. A conversion to a code therefore has to search for a match, report failure when none exists, and settle on one preferred code when more than one works.

Decoding is pure combinational logic. There is a free-standing decode port. A second decoder sits behind an operand picker: given a 32-bit instruction word, the picker returns either the expanded immediate held in bits 11..0 or an externally supplied register operand, depending on bit 25. Encoding is sequential. A constant is taken over a valid/ready handshake. The unit then tests one scale per clock, lowest first, and ends with a one-cycle done pulse carrying either a code with a success flag or a not-encodable result.

Top module: `imm_unit`

## Requirements
- R1: `dec_value` equals the zero-extended byte `dec_code[7:0]` rotated right by 2×`dec_code[11:8]` positions, modulo 32.
- R2: The decode paths are combinational: a change on `dec_code` or `instr` shows at the outputs within the same clock cycle.
- R3: When `instr[25]` is 1, `opnd_out` is the expansion of `instr[11:0]` under the R1 rule. When it is 0, `opnd_out` equals `reg_opnd`.
- R4: A constant is accepted only at a clock edge where `enc_valid` and `enc_ready` are both high. `enc_ready` is low from the cycle after acceptance until the done pulse. A `enc_valid` raised while `enc_ready` is low is ignored and yields no result.
- R5: On success `enc_ok` is 1 and `enc_code` holds the code with the lowest scale field `enc_code[11:8]` whose expansion equals the constant.
- R6: A constant that no code expands to ends with `enc_ok` = 0 and `enc_code` = 0. It is never truncated into a code.
- R7: `enc_done` is a single-cycle pulse. It rises (scale+1) clock edges after the accepting edge on success, and 16 edges after it on failure.
- R8: After reset `enc_ready` = 1, `enc_done` = 0, `enc_ok` = 0 and `enc_code` = 0.
- R9: Across all 4096 codes exactly 3073 distinct values arise, and every successful encoding decodes back to the requested constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_code | input | 12 | Immediate code to expand |
| dec_value | output | 32 | Expanded value of `dec_code` |
| instr | input | 32 | Instruction word for the operand picker |
| reg_opnd | input | 32 | Register operand value |
| opnd_out | output | 32 | Selected second operand |
| enc_valid | input | 1 | Encode request valid |
| enc_ready | output | 1 | Encoder idle and able to accept |
| enc_const | input | 32 | Constant to encode |
| enc_done | output | 1 | One-cycle pulse: encode result valid |
| enc_ok | output | 1 | Constant was encodable |
| enc_code | output | 12 | Resulting code (zero when not encodable) |

## Verification
A scale counter that skips or repeats a step shows up at the ports in two ways. The done pulse arrives at the wrong distance from acceptance, or a higher-scale alias is returned in place of the lowest one. Both are visible within 17 cycles of the request. A wrong match test shows as a code that does not expand back to the constant, or as a false not-encodable result, in that same done cycle. A stale busy flag shows as a missing pulse, as a second pulse, or as a request taken while a search is still running.

// File: rtl/imm_pkg.sv
package imm_pkg;
  localparam int WORD_W     = 32;
  localparam int BASE_W     = 8;
  localparam int SCALE_W    = 4;
  localparam int CODE_W     = BASE_W + SCALE_W;
  localparam int NUM_SCALES = 1 << SCALE_W;
  localparam int ROT_W      = $clog2(WORD_W);

  function automatic logic [WORD_W-1:0] rot_right(input logic [WORD_W-1:0] v,
                                                  input logic [ROT_W-1:0]  n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} >> n;
    return dbl[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] rot_left(input logic [WORD_W-1:0] v,
                                                 input logic [ROT_W-1:0]  n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} << n;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  // rotation amount for a scale field: twice the scale
  function automatic logic [ROT_W-1:0] scale_amt(input logic [SCALE_W-1:0] s);
    return ROT_W'({s, 1'b0});
  endfunction
endpackage

// File: rtl/imm_expand.sv
module imm_expand
  import imm_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] value_o
);
  logic [WORD_W-1:0] base_ext;

  always_comb begin
    base_ext             = '0;
    base_ext[BASE_W-1:0] = code_i[BASE_W-1:0];
    value_o              = rot_right(base_ext, scale_amt(code_i[CODE_W-1:BASE_W]));
  end

  // a zero scale leaves the byte in place
  always_comb begin
    if (code_i[CODE_W-1:BASE_W] == '0)
      AST_UNSCALED_PASS: assert (value_o[WORD_W-1:BASE_W] == '0 &&
                                 value_o[BASE_W-1:0] == code_i[BASE_W-1:0]); // R1
  end
endmodule

// File: rtl/imm_opnd_sel.sv
module imm_opnd_sel
  import imm_pkg::*;
#(
  parameter int IMM_SEL_BIT = 25
) (
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] reg_opnd_i,
  output logic [WORD_W-1:0] opnd_o
);
  logic [WORD_W-1:0] imm_val;

  imm_expand i_expand (
    .code_i  (instr_i[CODE_W-1:0]),
    .value_o (imm_val)
  );

  always_comb begin
    opnd_o = instr_i[IMM_SEL_BIT] ? imm_val : reg_opnd_i;
  end

  always_comb begin
    if (!instr_i[IMM_SEL_BIT])
      AST_REG_ROUTED: assert (opnd_o == reg_opnd_i); // R3
  end
endmodule

// File: rtl/imm_search.sv
module imm_search
  import imm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [WORD_W-1:0] req_const_i,
  output logic              done_o,
  output logic              ok_o,
  output logic [CODE_W-1:0] code_o
);
  logic               busy_q, busy_d;
  logic [SCALE_W-1:0] scale_q, scale_d;
  logic [WORD_W-1:0]  const_q;
  logic               done_q, done_d;
  logic               ok_q, ok_d;
  logic [CODE_W-1:0]  code_q, code_d;
  logic               accept, hit, last, res_en;
  logic [WORD_W-1:0]  rolled;

  assign req_ready_o = ~busy_q;
  assign accept      = req_valid_i & ~busy_q;

  // undo the rotation for the scale under test; a fit in the byte is a match
  always_comb begin
    rolled = rot_left(const_q, scale_amt(scale_q));
    hit    = ~|rolled[WORD_W-1:BASE_W];
    last   = (scale_q == SCALE_W'(NUM_SCALES - 1));
  end

  always_comb begin
    busy_d  = busy_q;
    scale_d = scale_q;
    done_d  = 1'b0;
    ok_d    = ok_q;
    code_d  = code_q;
    res_en  = 1'b0;
    if (accept) begin
      busy_d  = 1'b1;
      scale_d = '0;
    end else if (busy_q) begin
      if (hit) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_en = 1'b1;
        ok_d   = 1'b1;
        code_d = {scale_q, rolled[BASE_W-1:0]};
      end else if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_en = 1'b1;
        ok_d   = 1'b0;
        code_d = '0;
      end else begin
        scale_d = scale_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      scale_q <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      scale_q <= scale_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      const_q <= '0;
    end else if (accept) begin
      const_q <= req_const_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      code_q <= '0;
    end else if (res_en) begin
      ok_q   <= ok_d;
      code_q <= code_d;
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign code_o = code_q;

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_MISS_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last && !hit) |=> (done_q && !ok_q && code_q == '0)); // R6
  AST_CODE_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ok_q) |-> (rot_right(WORD_W'(code_q[BASE_W-1:0]),
                          scale_amt(code_q[CODE_W-1:BASE_W])) == const_q)); // R9
endmodule

// File: rtl/imm_unit.sv
module imm_unit
  import imm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] dec_code,
  output logic [31:0] dec_value,
  input  logic [31:0] instr,
  input  logic [31:0] reg_opnd,
  output logic [31:0] opnd_out,
  input  logic        enc_valid,
  output logic        enc_ready,
  input  logic [31:0] enc_const,
  output logic        enc_done,
  output logic        enc_ok,
  output logic [11:0] enc_code
);
  imm_expand i_dec (
    .code_i  (dec_code),
    .value_o (dec_value)
  );

  imm_opnd_sel #(.IMM_SEL_BIT(25)) i_sel (
    .instr_i    (instr),
    .reg_opnd_i (reg_opnd),
    .opnd_o     (opnd_out)
  );

  imm_search i_search (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (enc_valid),
    .req_ready_o (enc_ready),
    .req_const_i (enc_const),
    .done_o      (enc_done),
    .ok_o        (enc_ok),
    .code_o      (enc_code)
  );
endmodule

// File: tb/test_imm_unit.sv
module test_imm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] dec_code = '0;
  logic [31:0] dec_value;
  logic [31:0] instr = '0;
  logic [31:0] reg_opnd = '0;
  logic [31:0] opnd_out;
  logic        enc_valid = 1'b0;
  logic        enc_ready;
  logic [31:0] enc_const = '0;
  logic        enc_done;
  logic        enc_ok;
  logic [11:0] enc_code;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] c;
    logic        ok;
    logic [11:0] code;
    int          stamp;
  } exp_t;
  exp_t sbq[$];
  logic [11:0] first_code [logic [31:0]];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  imm_unit i_imm_unit (
    .clk(clk), .rst_n(rst_n), .dec_code(dec_code), .dec_value(dec_value),
    .instr(instr), .reg_opnd(reg_opnd), .opnd_out(opnd_out),
    .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_const(enc_const),
    .enc_done(enc_done), .enc_ok(enc_ok), .enc_code(enc_code)
  );

  function automatic logic [31:0] ref_expand(input logic [11:0] k);
    logic [31:0] b;
    int          r;
    b = {24'd0, k[7:0]};
    r = 2 * int'(k[11:8]);
    if (r == 0) return b;
    return (b >> r) | (b << (32 - r));
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: push the expected result, then present the request
  task automatic encode(input logic [31:0] c);
    exp_t e;
    @(negedge clk);
    while (!enc_ready) @(negedge clk);
    e.c     = c;
    e.ok    = first_code.exists(c);
    e.code  = e.ok ? first_code[c] : 12'd0;
    e.stamp = cyc;
    sbq.push_back(e);
    enc_valid = 1'b1;
    enc_const = c;
    @(negedge clk);
    enc_valid = 1'b0;
  endtask

  // monitor: pop and compare on each done pulse
  always @(negedge clk) begin
    if (rst_n && enc_done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R4", "unexpected done", 32'(enc_code), 32'd0);
      end else begin
        exp_t e;
        int   lat;
        e   = sbq.pop_front();
        lat = cyc - e.stamp - 1;
        check(enc_ok == e.ok, e.ok ? "R5" : "R6", "ok flag", 32'(enc_ok), 32'(e.ok));
        check(enc_code == e.code, e.ok ? "R5" : "R6", "code", 32'(enc_code), 32'(e.code));
        check(lat == (e.ok ? int'(e.code[11:8]) + 1 : 16), "R7", "latency",
              32'(lat), 32'(e.ok ? int'(e.code[11:8]) + 1 : 16));
        if (enc_ok)
          check(ref_expand(enc_code) == e.c, "R9", "roundtrip", ref_expand(enc_code), e.c);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(enc_ready == 1'b1, "R8", "ready", 32'(enc_ready), 32'd1);
    check(enc_done == 1'b0, "R8", "done", 32'(enc_done), 32'd0);
    check(enc_ok == 1'b0, "R8", "ok", 32'(enc_ok), 32'd0);
    check(enc_code == 12'd0, "R8", "code", 32'(enc_code), 32'd0);

    // R1 R2 exhaustive decode, sampled within the same cycle
    for (int k = 0; k < 4096; k++) begin
      dec_code = 12'(k);
      #0.5;
      check(dec_value == ref_expand(12'(k)), "R1", "decode", dec_value, ref_expand(12'(k)));
      if (!first_code.exists(ref_expand(12'(k))))
        first_code[ref_expand(12'(k))] = 12'(k);
    end
    check(first_code.num() == 3073, "R9", "distinct values", 32'(first_code.num()), 32'd3073);
    @(negedge clk);
    dec_code = 12'h4FF;
    #1;
    check(dec_value == 32'hFF000000, "R2", "same-cycle decode", dec_value, 32'hFF000000);

    // R3 operand picker
    reg_opnd = 32'hDEADBEEF;
    instr = 32'hE3A01FFF;
    #1;
    check(opnd_out == 32'h000003FC, "R3", "imm select", opnd_out, 32'h000003FC);
    instr = 32'hE1A01FFF;
    #1;
    check(opnd_out == 32'hDEADBEEF, "R3", "reg select", opnd_out, 32'hDEADBEEF);
    instr = 32'hE3A0E1FF;
    #1;
    check(opnd_out == 32'hC000003F, "R3", "imm wrap", opnd_out, 32'hC000003F);

    // R5 corner encodings with known canonical codes
    check(first_code[32'h00000001] == 12'h001, "R5", "alias of 1", 32'(first_code[32'h1]), 32'h001);
    check(first_code[32'h000003FC] == 12'hFFF, "R5", "top scale", 32'(first_code[32'h3FC]), 32'hFFF);
    encode(32'h00000000);
    encode(32'h00000001);
    encode(32'hFF000000);
    encode(32'hC000003F);
    encode(32'h000003FC);
    // R6 unreachable constants
    encode(32'h00000101);
    encode(32'hFFFFFFFF);
    encode(32'h00000102);

    // R4 valid while busy is ignored
    encode(32'h00000400);
    enc_valid = 1'b1;
    enc_const = 32'h00000101;
    check(enc_ready == 1'b0, "R4", "ready low while busy", 32'(enc_ready), 32'd0);
    @(negedge clk);
    enc_valid = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);

    // R9 every encodable value round-trips
    foreach (first_code[v]) encode(v);
    for (int i = 0; i < 200; i++) encode($urandom);

    while (sbq.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule